// File: doc/BRIEF.md
# Instruction Repeat Loop Buffer

This block sits in the instruction fetch path of a signal-processing core. A start command names a block of consecutive instruction words by its first address, its length and a repeat count. The buffer fetches the block once from program memory. Each word goes to the decoder as it arrives and is also written into a small local store. The buffer then issues the block again from that store for as many further passes as the count asks. It makes no program-memory request during those passes, and it flags the program bus as free so that data transfers can use it.

When the final pass ends, the buffer pulses a completion strobe and returns to idle. It also presents the address that follows the block, so the fetch unit can resume there. Commands with an impossible length are refused with an error strobe. An abort input ends a loop at once.

Top module: `loop_buffer`

## Requirements
- R1: A start command sampled in idle with a length from 1 to DEPTH (16 by default) is accepted. From the next cycle busy_o is high and pm_req_o is high with pm_addr_o equal to the block's first address.
- R2: During the capture pass, each cycle with pm_req_o and pm_valid_i high accepts pm_data_i. That word appears on ins_data_o with ins_valid_o high in the following cycle, and pm_addr_o then moves on by one. ins_valid_o is low in fill cycles with no accepted word.
- R3: After capture, the stored block is issued again in address order, one word per cycle, with no gaps. A repeat count of N gives N+1 executions in total. A count of 0 executes the block once and never enters replay.
- R4: bus_free_o is high exactly while the replay passes run, and pm_req_o is never high in a cycle where bus_free_o is high.
- R5: done_o is high for exactly one cycle, in the cycle after the last word of the final pass is shown on ins_valid_o. busy_o is already low in that cycle. resume_pc_o equals the start address plus the length from the cycle after acceptance onward.
- R6: A start command in idle with length 0 or a length above DEPTH raises err_o for one cycle. busy_o and pm_req_o stay low and resume_pc_o keeps its old value.
- R7: abort_i sampled while busy returns the buffer to idle in the next cycle. busy_o, pm_req_o, bus_free_o and ins_valid_o are low, and done_o does not pulse for that loop. abort_i in idle has no effect.
- R8: A start command sampled while busy is ignored: the running loop continues unchanged and resume_pc_o keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start command strobe |
| start_addr_i | input | AW | First address of the block |
| start_len_i | input | LW | Block length in words |
| start_cnt_i | input | CW | Extra passes after the first |
| abort_i | input | 1 | Ends the current loop |
| pm_req_o | output | 1 | Program-memory fetch request |
| pm_addr_o | output | AW | Fetch address |
| pm_valid_i | input | 1 | Fetch word accepted this cycle |
| pm_data_i | input | IW | Fetched instruction word |
| ins_valid_o | output | 1 | Instruction strobe to decoder |
| ins_data_o | output | IW | Instruction word to decoder |
| busy_o | output | 1 | Loop in progress |
| done_o | output | 1 | One-cycle completion strobe |
| err_o | output | 1 | One-cycle refused-command strobe |
| bus_free_o | output | 1 | Program bus free for data use |
| resume_pc_o | output | AW | Address following the block |

## Verification
Two conflicts on the same cycle are provoked on purpose. In the first, abort_i is driven so that it is sampled on the very edge that issues the last word of the final pass. Abort must win: that word is not shown and no done_o pulse follows. In the second, a new start command is presented in the cycle where done_o is high. busy_o has already fallen by then, so the new loop must be accepted at once. The bench's cycle model judges both cases, and an explicit check confirms that no completion strobe appeared after the abort.

// File: rtl/lb_pkg.sv
package lb_pkg;
  typedef enum logic [1:0] {
    LB_IDLE   = 2'd0,
    LB_FILL   = 2'd1,
    LB_REPLAY = 2'd2
  } lb_state_e;
endpackage

// File: rtl/lb_store.sv
// Simple dual-port word store: one write port, one registered read port.
module lb_store #(
  parameter int DEPTH = 16,
  parameter int IW    = 24,
  localparam int IXW  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic           clk,
  input  logic           we,
  input  logic [IXW-1:0] waddr,
  input  logic [IW-1:0]  wdata,
  input  logic           re,
  input  logic [IXW-1:0] raddr,
  output logic [IW-1:0]  rdata
);
  logic [IW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/lb_seq.sv
// Loop sequencer: capture pass, replay passes, completion and abort.
module lb_seq
  import lb_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 16,
  parameter int CW    = 8,
  localparam int IXW  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_i,
  input  logic [AW-1:0]  start_addr_i,
  input  logic [LW-1:0]  start_len_i,
  input  logic [CW-1:0]  start_cnt_i,
  input  logic           abort_i,
  input  logic           pm_valid_i,
  output logic           pm_req_o,
  output logic [AW-1:0]  pm_addr_o,
  output logic           wr_en_o,
  output logic [IXW-1:0] wr_idx_o,
  output logic           rd_en_o,
  output logic [IXW-1:0] rd_idx_o,
  output logic           ins_valid_o,
  output logic           src_replay_o,
  output logic           busy_o,
  output logic           done_o,
  output logic           err_o,
  output logic           bus_free_o,
  output logic [AW-1:0]  resume_pc_o
);
  lb_state_e      state;
  logic [IXW-1:0] widx, ridx, last_idx;
  logic [CW-1:0]  cnt_q, left_q;
  logic           fin_q;
  logic           len_bad;

  assign len_bad  = (start_len_i == '0) || (start_len_i > LW'(DEPTH));
  assign wr_en_o  = (state == LB_FILL) && pm_valid_i && !abort_i;
  assign wr_idx_o = widx;
  assign rd_en_o  = (state == LB_REPLAY) && !abort_i;
  assign rd_idx_o = ridx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= LB_IDLE;
      widx         <= '0;
      ridx         <= '0;
      last_idx     <= '0;
      cnt_q        <= '0;
      left_q       <= '0;
      fin_q        <= 1'b0;
      pm_req_o     <= 1'b0;
      pm_addr_o    <= '0;
      ins_valid_o  <= 1'b0;
      src_replay_o <= 1'b0;
      busy_o       <= 1'b0;
      done_o       <= 1'b0;
      err_o        <= 1'b0;
      bus_free_o   <= 1'b0;
      resume_pc_o  <= '0;
    end else begin
      ins_valid_o <= 1'b0;
      err_o       <= 1'b0;
      fin_q       <= 1'b0;
      done_o      <= fin_q;
      if (abort_i && (state != LB_IDLE)) begin
        state      <= LB_IDLE;
        pm_req_o   <= 1'b0;
        busy_o     <= 1'b0;
        bus_free_o <= 1'b0;
      end else begin
        case (state)
          LB_IDLE: begin
            if (start_i) begin
              if (len_bad) begin
                err_o <= 1'b1;
              end else begin
                state       <= LB_FILL;
                pm_req_o    <= 1'b1;
                pm_addr_o   <= start_addr_i;
                busy_o      <= 1'b1;
                resume_pc_o <= start_addr_i + AW'(start_len_i);
                last_idx    <= IXW'(start_len_i - LW'(1));
                cnt_q       <= start_cnt_i;
                widx        <= '0;
              end
            end
          end
          LB_FILL: begin
            if (pm_valid_i) begin
              ins_valid_o  <= 1'b1;
              src_replay_o <= 1'b0;
              if (widx == last_idx) begin
                pm_req_o <= 1'b0;
                if (cnt_q == '0) begin
                  state  <= LB_IDLE;
                  busy_o <= 1'b0;
                  fin_q  <= 1'b1;
                end else begin
                  state      <= LB_REPLAY;
                  bus_free_o <= 1'b1;
                  ridx       <= '0;
                  left_q     <= cnt_q;
                end
              end else begin
                widx      <= widx + IXW'(1);
                pm_addr_o <= pm_addr_o + AW'(1);
              end
            end
          end
          LB_REPLAY: begin
            ins_valid_o  <= 1'b1;
            src_replay_o <= 1'b1;
            if (ridx == last_idx) begin
              ridx <= '0;
              if (left_q == CW'(1)) begin
                state      <= LB_IDLE;
                busy_o     <= 1'b0;
                bus_free_o <= 1'b0;
                fin_q      <= 1'b1;
              end else begin
                left_q <= left_q - CW'(1);
              end
            end else begin
              ridx <= ridx + IXW'(1);
            end
          end
          default: state <= LB_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/loop_buffer.sv
module loop_buffer #(
  parameter int DEPTH = 16,
  parameter int AW    = 16,
  parameter int IW    = 24,
  parameter int CW    = 8,
  localparam int IXW  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [LW-1:0] start_len_i,
  input  logic [CW-1:0] start_cnt_i,
  input  logic          abort_i,
  output logic          pm_req_o,
  output logic [AW-1:0] pm_addr_o,
  input  logic          pm_valid_i,
  input  logic [IW-1:0] pm_data_i,
  output logic          ins_valid_o,
  output logic [IW-1:0] ins_data_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic          bus_free_o,
  output logic [AW-1:0] resume_pc_o
);
  logic           wr_en, rd_en, src_replay;
  logic [IXW-1:0] wr_idx, rd_idx;
  logic [IW-1:0]  rd_word, fill_q;

  lb_seq #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .start_addr_i (start_addr_i),
    .start_len_i  (start_len_i),
    .start_cnt_i  (start_cnt_i),
    .abort_i      (abort_i),
    .pm_valid_i   (pm_valid_i),
    .pm_req_o     (pm_req_o),
    .pm_addr_o    (pm_addr_o),
    .wr_en_o      (wr_en),
    .wr_idx_o     (wr_idx),
    .rd_en_o      (rd_en),
    .rd_idx_o     (rd_idx),
    .ins_valid_o  (ins_valid_o),
    .src_replay_o (src_replay),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .err_o        (err_o),
    .bus_free_o   (bus_free_o),
    .resume_pc_o  (resume_pc_o)
  );

  lb_store #(.DEPTH(DEPTH), .IW(IW)) u_store (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_idx),
    .wdata (pm_data_i),
    .re    (rd_en),
    .raddr (rd_idx),
    .rdata (rd_word)
  );

  // Capture-pass forwarding register, aligned with the store read latency.
  always_ff @(posedge clk) begin
    if (rst)        fill_q <= '0;
    else if (wr_en) fill_q <= pm_data_i;
  end

  assign ins_data_o = src_replay ? rd_word : fill_q;
endmodule

// File: rtl/lb_checks.sv
module lb_checks #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          start_i,
  input logic          abort_i,
  input logic          pm_req_o,
  input logic          ins_valid_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic          bus_free_o,
  input logic [AW-1:0] resume_pc_o
);
  assert_bus_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    bus_free_o |-> !pm_req_o);

  assert_free_needs_busy_R4: assert property (@(posedge clk) disable iff (rst)
    bus_free_o |-> busy_o);

  assert_done_follows_issue_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(ins_valid_o) && !busy_o);

  assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_err_idle_R6: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !busy_o && !pm_req_o);

  assert_abort_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (busy_o && abort_i) |=> !busy_o && !pm_req_o && !bus_free_o && !ins_valid_o);

  assert_abort_no_done_R7: assert property (@(posedge clk) disable iff (rst)
    (busy_o && abort_i) |=> ##1 !done_o);

  assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && !abort_i) |=> $stable(resume_pc_o));
endmodule

bind loop_buffer lb_checks #(.AW(AW)) u_lb_checks (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .abort_i     (abort_i),
  .pm_req_o    (pm_req_o),
  .ins_valid_o (ins_valid_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .bus_free_o  (bus_free_o),
  .resume_pc_o (resume_pc_o)
);

// File: tb/tb_loop_buffer.sv
`timescale 1ns/1ps
module tb_loop_buffer;
  localparam int DEPTH = 16;
  localparam int AW = 16;
  localparam int IW = 24;
  localparam int CW = 8;
  localparam int LW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [AW-1:0] start_addr_i = '0;
  logic [LW-1:0] start_len_i = '0;
  logic [CW-1:0] start_cnt_i = '0;
  logic abort_i = 1'b0;
  logic pm_req_o;
  logic [AW-1:0] pm_addr_o;
  logic pm_valid_i = 1'b0;
  logic [IW-1:0] pm_data_i;
  logic ins_valid_o;
  logic [IW-1:0] ins_data_o;
  logic busy_o, done_o, err_o, bus_free_o;
  logic [AW-1:0] resume_pc_o;

  int total = 0;
  int bad = 0;
  int vmode = 0;
  int issued = 0;
  int done_seen = 0;

  always #2 clk = ~clk;

  function automatic logic [IW-1:0] word_at(logic [AW-1:0] a);
    return IW'(a * 13) ^ 24'h05A5A5;
  endfunction

  assign pm_data_i = word_at(pm_addr_o);

  loop_buffer #(.DEPTH(DEPTH), .AW(AW), .IW(IW), .CW(CW)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .start_addr_i(start_addr_i),
    .start_len_i(start_len_i), .start_cnt_i(start_cnt_i), .abort_i(abort_i),
    .pm_req_o(pm_req_o), .pm_addr_o(pm_addr_o), .pm_valid_i(pm_valid_i),
    .pm_data_i(pm_data_i), .ins_valid_o(ins_valid_o), .ins_data_o(ins_data_o),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .bus_free_o(bus_free_o),
    .resume_pc_o(resume_pc_o)
  );

  // Behavioural reference: values expected after each rising edge.
  int m_state = 0, m_widx = 0, m_ridx = 0, m_left = 0, m_len = 0, m_cnt = 0;
  logic [IW-1:0] m_buf [DEPTH];
  logic e_val = 0, e_req = 0, e_busy = 0, e_free = 0, e_done = 0, e_fin = 0, e_err = 0;
  logic [IW-1:0] e_data = '0;
  logic [AW-1:0] e_addr = '0, e_pc = '0;

  always @(posedge clk) begin
    e_done = e_fin; e_fin = 0; e_err = 0; e_val = 0;
    if (rst) begin
      m_state = 0; e_req = 0; e_busy = 0; e_free = 0; e_done = 0;
      e_addr = '0; e_pc = '0;
    end else if (m_state != 0 && abort_i) begin
      m_state = 0; e_req = 0; e_busy = 0; e_free = 0;
    end else if (m_state == 0) begin
      if (start_i) begin
        if (start_len_i == 0 || int'(start_len_i) > DEPTH) e_err = 1;
        else begin
          m_state = 1; m_len = int'(start_len_i); m_cnt = int'(start_cnt_i);
          m_widx = 0; e_addr = start_addr_i; e_req = 1; e_busy = 1;
          e_pc = start_addr_i + AW'(start_len_i);
        end
      end
    end else if (m_state == 1) begin
      if (pm_valid_i) begin
        e_val = 1; e_data = word_at(e_addr); m_buf[m_widx] = e_data;
        if (m_widx == m_len - 1) begin
          e_req = 0;
          if (m_cnt == 0) begin m_state = 0; e_busy = 0; e_fin = 1; end
          else begin m_state = 2; e_free = 1; m_ridx = 0; m_left = m_cnt; end
        end else begin
          m_widx++; e_addr = e_addr + 1;
        end
      end
    end else begin
      e_val = 1; e_data = m_buf[m_ridx];
      if (m_ridx == m_len - 1) begin
        m_ridx = 0;
        if (m_left == 1) begin m_state = 0; e_busy = 0; e_free = 0; e_fin = 1; end
        else m_left--;
      end else m_ridx++;
    end
  end

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, away from the rising edge.
  always @(negedge clk) begin
    if (!rst) begin
      chk(busy_o == e_busy, "R1 busy", busy_o, e_busy);
      chk(pm_req_o == e_req, "R1 pm_req", pm_req_o, e_req);
      if (e_req) chk(pm_addr_o == e_addr, "R2 pm_addr", pm_addr_o, e_addr);
      chk(ins_valid_o == e_val, "R2 ins_valid", ins_valid_o, e_val);
      if (e_val) chk(ins_data_o == e_data, "R3 ins_data", ins_data_o, e_data);
      chk(bus_free_o == e_free, "R4 bus_free", bus_free_o, e_free);
      chk(!(bus_free_o && pm_req_o), "R4 req while free", pm_req_o, 0);
      chk(done_o == e_done, "R5 done", done_o, e_done);
      chk(resume_pc_o == e_pc, "R5 resume_pc", resume_pc_o, e_pc);
      chk(err_o == e_err, "R6 err", err_o, e_err);
      if (ins_valid_o) issued++;
      if (done_o) done_seen++;
    end
    pm_valid_i <= (vmode == 0) ? 1'b1 : 1'($urandom_range(0, 1));
  end

  task automatic do_start(input int a, input int len, input int cnt);
    @(negedge clk);
    start_i <= 1'b1; start_addr_i <= AW'(a); start_len_i <= LW'(len); start_cnt_i <= CW'(cnt);
    @(negedge clk);
    start_i <= 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (done_o) break;
    end
    @(negedge clk);
  endtask

  task automatic run_loop(input int a, input int len, input int cnt, input string tag);
    issued = 0; done_seen = 0;
    do_start(a, len, cnt);
    wait_done();
    chk(issued == len * (cnt + 1), tag, issued, len * (cnt + 1));
    chk(done_seen == 1, "R5 one done pulse", done_seen, 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst <= 1'b0;
    @(negedge clk);
    chk(!busy_o && !pm_req_o && !ins_valid_o && !done_o, "R1 reset state", busy_o, 0);

    run_loop(16'h0100, 4, 2, "R3 len4 cnt2 issue count");
    run_loop(16'h0200, 3, 0, "R3 cnt0 runs once");
    vmode = 1;
    run_loop(16'h0400, 16, 1, "R3 full depth gapped fill");
    run_loop(16'h0FFE, 1, 5, "R3 single word");
    vmode = 0;

    // R6: illegal lengths
    do_start(16'h0700, 0, 3);
    chk(!busy_o && resume_pc_o == 16'h0FFF, "R6 len0 refused", resume_pc_o, 16'h0FFF);
    do_start(16'h0700, 17, 3);
    chk(!busy_o, "R6 len17 refused", busy_o, 0);
    repeat (2) @(negedge clk);

    // R8: start while busy ignored
    issued = 0;
    do_start(16'h0300, 5, 3);
    repeat (8) @(negedge clk);
    start_i <= 1'b1; start_addr_i <= 16'h0500; start_len_i <= 2; start_cnt_i <= 0;
    @(negedge clk); start_i <= 1'b0;
    wait_done();
    chk(issued == 20, "R8 loop unchanged by busy start", issued, 20);
    chk(resume_pc_o == 16'h0305, "R8 resume pc kept", resume_pc_o, 16'h0305);

    // R7: abort in replay and in idle
    issued = 0; done_seen = 0;
    do_start(16'h0800, 4, 9);
    repeat (9) @(negedge clk);
    abort_i <= 1'b1; @(negedge clk); abort_i <= 1'b0;
    chk(!busy_o && !bus_free_o, "R7 abort ends loop", busy_o, 0);
    repeat (3) @(negedge clk);
    chk(done_seen == 0, "R7 no done after abort", done_seen, 1'b0);
    abort_i <= 1'b1; @(negedge clk); abort_i <= 1'b0;
    chk(!busy_o && !err_o, "R7 abort in idle harmless", busy_o, 0);

    // R7: abort on the edge that issues the final word
    done_seen = 0;
    do_start(16'h0900, 2, 1);
    for (int i = 0; i < 50; i++) begin
      if (m_state == 2 && m_ridx == m_len - 1 && m_left == 1) break;
      @(negedge clk);
    end
    abort_i <= 1'b1; @(negedge clk); abort_i <= 1'b0;
    repeat (3) @(negedge clk);
    chk(done_seen == 0, "R7 abort beats last issue", done_seen, 0);

    // R5/R1: start presented in the done cycle is accepted
    issued = 0;
    do_start(16'h0A00, 3, 1);
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (done_o) break;
    end
    start_i <= 1'b1; start_addr_i <= 16'h0B00; start_len_i <= 2; start_cnt_i <= 2;
    @(negedge clk); start_i <= 1'b0;
    chk(busy_o && pm_addr_o == 16'h0B00, "R1 start in done cycle", pm_addr_o, 16'h0B00);
    wait_done();
    chk(resume_pc_o == 16'h0B02, "R5 resume after chained loop", resume_pc_o, 16'h0B02);

    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule